// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block moves a programmable-logic device out of configuration and into user mode. A one-cycle start request marks the end of configuration. The block then emits a one-cycle global set/reset pulse and walks a phase counter from 0 to 7. It advances at most once per edge of a chosen start-up clock. As the counter passes programmable phases, the block releases the DONE drive, lifts the global three-state hold and enables global writes, in that order by default. Once phase 7 is reached it stays there, with every output in its user-mode state, until a new start request or a reset.

The block runs on one system clock. Each of the three start-up clock sources (configuration clock, user clock, test-access clock) arrives as a single-cycle tick enable, and a select input picks which one paces the sequence. Two optional wait conditions can stall the count. One holds the count at a programmed phase until a clock-lock flag is high. The other holds it before the three-state or write-enable release phase until the externally sensed, wire-ANDed DONE line is high, so that chained devices start together. The user application can force set/reset and three-state at any time, and each force is ORed with the value the sequencer generates.

Top module: `cfg_startup_seq`

## Requirements
- R1: While reset is held, and after it, before any start request: `phase_o`=0, `done_rel_o`=0, `gts_o`=1, `gwe_o`=0, `gsr_o`=0, `pin_user_o`=0 and `pin_oe_o`=0, with the user overrides low.
- R2: A start request sampled on an edge leaves `phase_o`=0 and `gsr_o`=1 after that edge. `gsr_o` falls after the next edge unless another request arrives. A request restarts the sequence from any state.
- R3: While running below phase 7, `phase_o` rises by exactly one on each edge where the selected tick is high and no wait condition holds. Otherwise it is unchanged.
- R4: `clk_src_i` picks the tick. 0 selects `tick_cfg_i`, 1 selects `tick_usr_i`, 2 selects `tick_tck_i`, and 3 also selects `tick_cfg_i`.
- R5: `done_rel_o` is 1 while the sequence is running or finished and `phase_o` ≥ the DONE release phase. The reset default of that phase is 4.
- R6: The sequencer-generated three-state value is 0 once `phase_o` ≥ the three-state phase (default 5). `gwe_o` is 1 once `phase_o` ≥ the larger of the write-enable phase (default 6) and the three-state phase, so writes are never enabled while the sequencer still holds three-state.
- R7: With sync-to-DONE enabled and `done_sense_i` low, the phase never advances into the three-state phase or the effective write-enable phase.
- R8: With the lock wait enabled, the phase holds at the programmed lock phase while `lock_i` is low. The lock wait is disabled at reset.
- R9: A pulse on `cfg_wr_i` loads all six programmable fields only while no sequence is in progress (idle or at phase 7). During phases 0 to 6 it is ignored.
- R10: `gsr_o` is the sequencer pulse ORed with `usr_gsr_i`. `gts_o` is the sequencer three-state value ORed with `usr_gts_i`.
- R11: `pin_user_o` is `done_rel_o` AND `done_sense_i`. `pin_oe_o` is `pin_user_o` AND NOT `gts_o`.
- R12: After phase 7 is reached, the phase and all released outputs hold, whatever the ticks, lock and sense inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_i | input | 1 | Configuration-complete start request (single cycle) |
| clk_src_i | input | 2 | Start-up tick source select |
| tick_cfg_i | input | 1 | Configuration-clock tick enable |
| tick_usr_i | input | 1 | User-clock tick enable |
| tick_tck_i | input | 1 | Test-access-clock tick enable |
| done_sense_i | input | 1 | Sensed level of the shared DONE line |
| lock_i | input | 1 | Clock-lock indication |
| usr_gsr_i | input | 1 | User set/reset force |
| usr_gts_i | input | 1 | User three-state force |
| cfg_wr_i | input | 1 | Load strobe for the programmable fields |
| cfg_done_ph_i | input | 3 | DONE release phase |
| cfg_gts_ph_i | input | 3 | Three-state release phase |
| cfg_gwe_ph_i | input | 3 | Write-enable release phase |
| cfg_lock_ph_i | input | 3 | Lock-wait phase |
| cfg_lock_en_i | input | 1 | Lock-wait enable |
| cfg_sync_en_i | input | 1 | Sync-to-DONE enable |
| done_rel_o | output | 1 | DONE drive released (1 = let line go high) |
| gsr_o | output | 1 | Global set/reset |
| gts_o | output | 1 | Global three-state (1 = outputs held off) |
| gwe_o | output | 1 | Global write enable |
| pin_user_o | output | 1 | Dual-purpose pins in user-I/O mode |
| pin_oe_o | output | 1 | Dual-purpose pins may drive |
| phase_o | output | 3 | Current start-up phase |

## Verification
The bench programs a write-enable phase below the three-state phase. A design that compared against the raw field would enable writes while outputs are still three-stated. It holds the other chained device's DONE low with sync enabled, and a design that only checked sync on the three-state step would slip into the write-enable phase anyway. It holds lock low at a mid phase, and a design with the wrong compare would stall one phase off or not at all. It also writes a new DONE phase mid-run and restarts mid-run. A design that did not freeze its fields would release DONE early, and one that did not restart would never pulse set/reset again. A clock-source check confirms that the faster user tick finishes inside a window the slower configuration tick cannot meet.

// File: rtl/startup_pkg.sv
// Shared types for the start-up sequencer.
// Assumes: tick sources are single-cycle enables in the system clock domain.
package startup_pkg;

    typedef enum logic [1:0] {
        SRC_CFG     = 2'd0,
        SRC_USR     = 2'd1,
        SRC_TCK     = 2'd2,
        SRC_CFG_ALT = 2'd3
    } tick_src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_USER = 2'd2
    } seq_state_e;

endpackage

// File: rtl/startup_tick_sel.sv
// Picks one of three tick enables as the start-up pace.
// Assumes: each tick is a one-cycle pulse; the select is quasi-static.
module startup_tick_sel
    import startup_pkg::*;
(
    input  tick_src_e sel_i,
    input  logic      tick_cfg_i,
    input  logic      tick_usr_i,
    input  logic      tick_tck_i,
    output logic      tick_o
);

    // Source multiplexer; the spare code falls back to the configuration tick.
    always_comb begin
        unique case (sel_i)
            SRC_USR: tick_o = tick_usr_i;
            SRC_TCK: tick_o = tick_tck_i;
            default: tick_o = tick_cfg_i;
        endcase
    end

endmodule

// File: rtl/startup_cfg_regs.sv
// Holds the programmable release phases and wait enables.
// Loads only while no sequence is in progress; derives the effective
// write-enable phase so it never precedes the three-state release.
module startup_cfg_regs #(
    parameter int unsigned PHASE_W  = 3,
    parameter int unsigned DEF_DONE = 4,
    parameter int unsigned DEF_GTS  = 5,
    parameter int unsigned DEF_GWE  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               busy_i,
    input  logic [PHASE_W-1:0] done_ph_i,
    input  logic [PHASE_W-1:0] gts_ph_i,
    input  logic [PHASE_W-1:0] gwe_ph_i,
    input  logic [PHASE_W-1:0] lock_ph_i,
    input  logic               lock_en_i,
    input  logic               sync_en_i,
    output logic [PHASE_W-1:0] done_ph_o,
    output logic [PHASE_W-1:0] gts_ph_o,
    output logic [PHASE_W-1:0] gwe_eff_o,
    output logic [PHASE_W-1:0] lock_ph_o,
    output logic               lock_en_o,
    output logic               sync_en_o
);

    logic [PHASE_W-1:0] gwe_ph_q;

    // Field storage with reset defaults; writes gated off while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_ph_o <= PHASE_W'(DEF_DONE);
            gts_ph_o  <= PHASE_W'(DEF_GTS);
            gwe_ph_q  <= PHASE_W'(DEF_GWE);
            lock_ph_o <= '0;
            lock_en_o <= 1'b0;
            sync_en_o <= 1'b0;
        end else if (wr_i && !busy_i) begin
            done_ph_o <= done_ph_i;
            gts_ph_o  <= gts_ph_i;
            gwe_ph_q  <= gwe_ph_i;
            lock_ph_o <= lock_ph_i;
            lock_en_o <= lock_en_i;
            sync_en_o <= sync_en_i;
        end
    end

    // Write enable may not come before three-state release.
    always_comb begin
        gwe_eff_o = (gwe_ph_q < gts_ph_o) ? gts_ph_o : gwe_ph_q;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable({done_ph_o, gts_ph_o, gwe_ph_q, lock_ph_o, lock_en_o, sync_en_o})); // R9

endmodule

// File: rtl/startup_phase_fsm.sv
// Phase counter and run state of the start-up sequence.
// A start request restarts at phase 0 with a one-cycle set/reset pulse;
// the count advances on the selected tick unless a wait condition holds,
// and parks in the user state at the last phase.
module startup_phase_fsm
    import startup_pkg::*;
#(
    parameter int unsigned PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               tick_i,
    input  logic               lock_i,
    input  logic               done_sense_i,
    input  logic               lock_en_i,
    input  logic [PHASE_W-1:0] lock_ph_i,
    input  logic               sync_en_i,
    input  logic [PHASE_W-1:0] gts_ph_i,
    input  logic [PHASE_W-1:0] gwe_ph_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               running_o,
    output logic               busy_o,
    output logic               gsr_o
);

    localparam logic [PHASE_W-1:0] LAST_PH = '1;

    seq_state_e         state_q;
    logic [PHASE_W-1:0] nxt_ph;
    logic               lock_block;
    logic               sync_block;
    logic               adv;

    // Wait conditions and advance decision.
    always_comb begin
        nxt_ph     = phase_o + 1'b1;
        lock_block = lock_en_i && (phase_o == lock_ph_i) && !lock_i;
        sync_block = sync_en_i && !done_sense_i &&
                     ((nxt_ph == gts_ph_i) || (nxt_ph == gwe_ph_i));
        adv        = (state_q == ST_RUN) && tick_i && !lock_block && !sync_block;
    end

    // State, phase and set/reset pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_o <= '0;
            gsr_o   <= 1'b0;
        end else begin
            gsr_o <= start_i;
            if (start_i) begin
                state_q <= ST_RUN;
                phase_o <= '0;
            end else if (adv) begin
                phase_o <= nxt_ph;
                if (nxt_ph == LAST_PH) begin
                    state_q <= ST_USER;
                end
            end
        end
    end

    // Status views of the state.
    always_comb begin
        running_o = (state_q != ST_IDLE);
        busy_o    = (state_q == ST_RUN);
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (gsr_o && phase_o == '0)); // R2
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !start_i && !tick_i) |=> $stable(phase_o)); // R3
    AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !start_i && lock_en_i && phase_o == lock_ph_i && !lock_i)
        |=> $stable(phase_o)); // R8
    AST_SYNC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !start_i && sync_en_i && !done_sense_i &&
         (PHASE_W'(phase_o + 1'b1) == gts_ph_i)) |=> $stable(phase_o)); // R7
    AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USER && !start_i) |=> (phase_o == LAST_PH)); // R12

endmodule

// File: rtl/cfg_startup_seq.sv
// Top of the configuration start-up sequencer.
// Decodes release points from the phase, applies user overrides and
// derives the dual-purpose pin mode. Assumes the sensed DONE line is
// the wire-AND of every chained device's DONE release.
module cfg_startup_seq
    import startup_pkg::*;
#(
    parameter int unsigned PHASE_W  = 3,
    parameter int unsigned DEF_DONE = 4,
    parameter int unsigned DEF_GTS  = 5,
    parameter int unsigned DEF_GWE  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_start_i,
    input  logic [1:0]         clk_src_i,
    input  logic               tick_cfg_i,
    input  logic               tick_usr_i,
    input  logic               tick_tck_i,
    input  logic               done_sense_i,
    input  logic               lock_i,
    input  logic               usr_gsr_i,
    input  logic               usr_gts_i,
    input  logic               cfg_wr_i,
    input  logic [PHASE_W-1:0] cfg_done_ph_i,
    input  logic [PHASE_W-1:0] cfg_gts_ph_i,
    input  logic [PHASE_W-1:0] cfg_gwe_ph_i,
    input  logic [PHASE_W-1:0] cfg_lock_ph_i,
    input  logic               cfg_lock_en_i,
    input  logic               cfg_sync_en_i,
    output logic               done_rel_o,
    output logic               gsr_o,
    output logic               gts_o,
    output logic               gwe_o,
    output logic               pin_user_o,
    output logic               pin_oe_o,
    output logic [PHASE_W-1:0] phase_o
);

    logic               tick;
    logic               running;
    logic               busy;
    logic               gsr_seq;
    logic               gts_seq;
    logic [PHASE_W-1:0] done_ph;
    logic [PHASE_W-1:0] gts_ph;
    logic [PHASE_W-1:0] gwe_eff;
    logic [PHASE_W-1:0] lock_ph;
    logic               lock_en;
    logic               sync_en;

    startup_tick_sel u_tick (
        .sel_i      (tick_src_e'(clk_src_i)),
        .tick_cfg_i (tick_cfg_i),
        .tick_usr_i (tick_usr_i),
        .tick_tck_i (tick_tck_i),
        .tick_o     (tick)
    );

    startup_cfg_regs #(
        .PHASE_W  (PHASE_W),
        .DEF_DONE (DEF_DONE),
        .DEF_GTS  (DEF_GTS),
        .DEF_GWE  (DEF_GWE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr_i),
        .busy_i    (busy),
        .done_ph_i (cfg_done_ph_i),
        .gts_ph_i  (cfg_gts_ph_i),
        .gwe_ph_i  (cfg_gwe_ph_i),
        .lock_ph_i (cfg_lock_ph_i),
        .lock_en_i (cfg_lock_en_i),
        .sync_en_i (cfg_sync_en_i),
        .done_ph_o (done_ph),
        .gts_ph_o  (gts_ph),
        .gwe_eff_o (gwe_eff),
        .lock_ph_o (lock_ph),
        .lock_en_o (lock_en),
        .sync_en_o (sync_en)
    );

    startup_phase_fsm #(
        .PHASE_W (PHASE_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (cfg_start_i),
        .tick_i       (tick),
        .lock_i       (lock_i),
        .done_sense_i (done_sense_i),
        .lock_en_i    (lock_en),
        .lock_ph_i    (lock_ph),
        .sync_en_i    (sync_en),
        .gts_ph_i     (gts_ph),
        .gwe_ph_i     (gwe_eff),
        .phase_o      (phase_o),
        .running_o    (running),
        .busy_o       (busy),
        .gsr_o        (gsr_seq)
    );

    // Release decode from the current phase.
    always_comb begin
        done_rel_o = running && (phase_o >= done_ph);
        gts_seq    = !(running && (phase_o >= gts_ph));
        gwe_o      = running && (phase_o >= gwe_eff);
    end

    // User overrides and dual-purpose pin mode.
    always_comb begin
        gsr_o      = gsr_seq | usr_gsr_i;
        gts_o      = gts_seq | usr_gts_i;
        pin_user_o = done_rel_o & done_sense_i;
        pin_oe_o   = pin_user_o & ~gts_o;
    end

    AST_GWE_AFTER_GTS: assert property (@(posedge clk) disable iff (!rst_n)
        gwe_o |-> !gts_seq); // R6

endmodule

// File: tb/cfg_startup_seq_tb_top.sv
`timescale 1ns/1ps
module cfg_startup_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] src = 2'd0;
    logic       t_cfg = 1'b0, t_usr = 1'b0, t_tck = 1'b0;
    logic       lock = 1'b0;
    logic       other_done = 1'b1;
    logic       ugsr = 1'b0, ugts = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] w_done = 3'd4, w_gts = 3'd5, w_gwe = 3'd6, w_lph = 3'd0;
    logic       w_len = 1'b0, w_sen = 1'b0;
    logic       done_rel, gsr, gts, gwe, pin_user, pin_oe;
    logic [2:0] phase;
    wire        done_sense = done_rel & other_done;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    cfg_startup_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start_i(start), .clk_src_i(src),
        .tick_cfg_i(t_cfg), .tick_usr_i(t_usr), .tick_tck_i(t_tck),
        .done_sense_i(done_sense), .lock_i(lock), .usr_gsr_i(ugsr), .usr_gts_i(ugts),
        .cfg_wr_i(wr), .cfg_done_ph_i(w_done), .cfg_gts_ph_i(w_gts), .cfg_gwe_ph_i(w_gwe),
        .cfg_lock_ph_i(w_lph), .cfg_lock_en_i(w_len), .cfg_sync_en_i(w_sen),
        .done_rel_o(done_rel), .gsr_o(gsr), .gts_o(gts), .gwe_o(gwe),
        .pin_user_o(pin_user), .pin_oe_o(pin_oe), .phase_o(phase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Tick generators: configuration every 3, user every 2, test clock every 5.
    always @(posedge clk) begin
        #1;
        cyc++;
        t_cfg = (cyc % 3 == 0);
        t_usr = (cyc % 2 == 0);
        t_tck = (cyc % 5 == 0);
    end

    // Behavioural reference model.
    int m_run = 0, m_ph = 0, m_gsr = 0;
    int m_pd = 4, m_pg = 5, m_pw = 6, m_pl = 0, m_le = 0, m_se = 0;

    function automatic int eff_gwe();
        return (m_pw < m_pg) ? m_pg : m_pw;
    endfunction
    function automatic int e_done();
        return (m_run != 0 && m_ph >= m_pd) ? 1 : 0;
    endfunction
    function automatic int e_gts();
        return (!(m_run != 0 && m_ph >= m_pg) || ugts) ? 1 : 0;
    endfunction
    function automatic int e_gwe();
        return (m_run != 0 && m_ph >= eff_gwe()) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int tk;
        int sense;
        bit stall;
        tk    = (src == 2'd1) ? int'(t_usr) : (src == 2'd2) ? int'(t_tck) : int'(t_cfg);
        sense = e_done() & int'(other_done);
        stall = (m_le != 0 && m_ph == m_pl && !lock) ||
                (m_se != 0 && sense == 0 && (m_ph + 1 == m_pg || m_ph + 1 == eff_gwe()));
        cmp_on <= 1'b1;
        if (!rst_n) begin
            m_run <= 0; m_ph <= 0; m_gsr <= 0;
            m_pd <= 4; m_pg <= 5; m_pw <= 6; m_pl <= 0; m_le <= 0; m_se <= 0;
        end else begin
            m_gsr <= int'(start);
            if (wr && !(m_run != 0 && m_ph < 7)) begin
                m_pd <= w_done; m_pg <= w_gts; m_pw <= w_gwe;
                m_pl <= w_lph; m_le <= w_len; m_se <= w_sen;
            end
            if (start) begin
                m_run <= 1; m_ph <= 0;
            end else if (m_run != 0 && m_ph < 7 && tk != 0 && !stall) begin
                m_ph <= m_ph + 1;
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        int ed;
        if (cmp_on) begin
            ed = e_done();
            chk("R3 phase", phase, m_ph);
            chk("R5 done_rel", done_rel, ed);
            chk("R6 gts", gts, e_gts());
            chk("R6 gwe", gwe, e_gwe());
            chk("R2/R10 gsr", gsr, (m_gsr != 0 || ugsr) ? 1 : 0);
            chk("R11 pin_user", pin_user, ed & int'(other_done));
            chk("R11 pin_oe", pin_oe, (ed & int'(other_done)) & (e_gts() ^ 1));
            if (gwe && !ugts) chk("R6 gwe while gts held", gts, 0);
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic do_start();
        start = 1'b1;
        step();
        start = 1'b0;
        chk("R2 phase zero after start", phase, 0);
        chk("R2 gsr pulse", gsr, 1);
        step();
        chk("R2 gsr falls", gsr, 0);
    endtask

    task automatic do_write(input int d, input int g, input int w, input int lp,
                            input bit le, input bit se);
        w_done = 3'(d); w_gts = 3'(g); w_gwe = 3'(w); w_lph = 3'(lp);
        w_len = le; w_sen = se; wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic wait_phase(input int p, input int lim);
        for (int i = 0; i < lim && phase != 3'(p); i++) step();
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 phase", phase, 0); chk("R1 done", done_rel, 0); chk("R1 gts", gts, 1);
        chk("R1 gwe", gwe, 0);     chk("R1 gsr", gsr, 0);       chk("R1 pin_user", pin_user, 0);
        rst_n = 1'b1;
        step(4);
        chk("R1 idle after reset", phase, 0);
        chk("R1 pin_oe idle", pin_oe, 0);

        // Default sequence on the configuration tick
        src = 2'd0;
        do_start();
        step(40);
        chk("R12 parked at last phase", phase, 7);
        chk("R6 gwe released", gwe, 1);
        chk("R11 pins drive", pin_oe, 1);
        lock = 1'b0; other_done = 1'b0;
        step(10);
        chk("R12 phase holds", phase, 7);
        chk("R12 gwe holds", gwe, 1);
        other_done = 1'b1;

        // R10 overrides in user mode
        ugsr = 1'b1; ugts = 1'b1;
        step(2);
        chk("R10 gsr forced", gsr, 1);
        chk("R10 gts forced", gts, 1);
        chk("R11 pin_oe off under force", pin_oe, 0);
        ugsr = 1'b0; ugts = 1'b0;
        step(2);

        // R4 user tick, write-enable phase below three-state phase
        do_write(2, 3, 1, 0, 1'b0, 1'b0);
        src = 2'd1;
        do_start();
        step(14);
        chk("R4 user tick finishes in window", phase, 7);
        step(4);

        // R9 write ignored mid-run, test-access tick, restart mid-run
        do_write(4, 5, 6, 0, 1'b0, 1'b0);
        src = 2'd2;
        do_start();
        step(3);
        do_write(1, 5, 6, 0, 1'b0, 1'b0);
        wait_phase(2, 40);
        chk("R9 done not released early", done_rel, 0);
        do_start();
        wait_phase(7, 80);
        chk("R9 run completes with old fields", phase, 7);
        src = 2'd3;
        do_start();
        wait_phase(7, 60);
        chk("R4 spare code uses cfg tick", phase, 7);

        // R7 sync-to-DONE with another device holding DONE low
        do_write(4, 5, 6, 0, 1'b0, 1'b1);
        other_done = 1'b0;
        src = 2'd0;
        do_start();
        step(60);
        chk("R7 held before three-state phase", phase, 4);
        chk("R7 gts still held", gts, 1);
        other_done = 1'b1;
        step(30);
        chk("R7 completes after DONE seen", phase, 7);

        // R8 lock wait at phase 2
        do_write(4, 5, 6, 2, 1'b1, 1'b0);
        lock = 1'b0;
        do_start();
        step(50);
        chk("R8 held at lock phase", phase, 2);
        lock = 1'b1;
        step(30);
        chk("R8 completes after lock", phase, 7);

        // R1 reset mid-run restores defaults
        do_start();
        step(5);
        rst_n = 1'b0;
        step(2);
        chk("R1 reset mid-run phase", phase, 0);
        chk("R1 reset mid-run gts", gts, 1);
        rst_n = 1'b1;
        lock = 1'b0;
        do_start();
        step(40);
        chk("R8 lock wait disabled at reset", phase, 7);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule